// File: doc/BRIEF.md
# Designator-Selected Register File Unit

This block is the register and address unit of a byte-wide processor core. It holds sixteen 16-bit general registers, an 8-bit accumulator and two 4-bit designators. One designator picks the register that acts as the program counter. The other picks the register that acts as the data pointer. No register is fixed to either role. Software makes a call or a context switch by loading a new designator value.

Each cycle the block takes one micro-operation code and a 4-bit register number. It moves bytes between the accumulator and either half of a register. It loads or stores through a pointer register, with an optional step up or down. It can also change a designator, or fetch an instruction byte through the program counter.

The memory port expects a synchronous byte memory. The address and strobes come out in the cycle of the micro-operation, and read data returns in the next cycle. A byte loaded in one cycle is forwarded, so the next micro-operation can use it at once. Opcode decode, arithmetic and branching are handled elsewhere.

Top module: `rfu_core`

## Requirements
- R1: After reset, both designators are 0, the accumulator is 0 and every general register is 0, so the first fetch addresses byte 0 through register 0.
- R2: Code 1 (put-low) writes the accumulator into bits 7:0 of register `sel_i`, and code 2 (put-high) writes it into bits 15:8; the other byte of that register keeps its value.
- R3: Code 3 (get-low) and code 4 (get-high) copy bits 7:0 or bits 15:8 of register `sel_i` into the accumulator, visible on `acc_o` in the next cycle.
- R4: Code 5 loads `sel_i` into the program-counter designator and code 6 loads it into the data-pointer designator, both visible in the next cycle.
- R5: Code 7 (store and step down) raises `mem_we_o` with `mem_addr_o` equal to the data-pointer register and `mem_wdata_o` equal to the accumulator, then lowers that register by one.
- R6: Code 8 (load and step up) and code 9 (load in place) raise `mem_re_o` with `mem_addr_o` equal to the data-pointer register; code 8 then raises that register by one and code 9 leaves it unchanged; the byte returned in the next cycle becomes the accumulator.
- R7: Code 10 reads memory at register `sel_i` into the accumulator and then raises register `sel_i` by one.
- R8: Code 11 (fetch) reads memory at the program-counter register and raises it by one; in the next cycle `instr_valid_o` is 1 and `instr_o` carries the returned byte; in every other cycle `instr_valid_o` is 0.
- R9: A byte loaded in one cycle is the accumulator value seen by the next micro-operation: `acc_o`, store data and put-low/put-high all use it with no stall.
- R10: Pointer steps wrap modulo 2^16: stepping up from 0xFFFF gives 0x0000 and stepping down from 0x0000 gives 0xFFFF.
- R11: Code 0 and codes 12 to 15 are no-operations: no memory strobe, and the designators, accumulator and registers keep their values.
- R12: No cycle raises `mem_re_o` and `mem_we_o` together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Micro-operation code |
| sel_i | input | 4 | Register number for register-selecting codes |
| mem_addr_o | output | 16 | Memory byte address |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after a read strobe |
| acc_o | output | 8 | Current accumulator value, including a byte landing this cycle |
| pc_sel_o | output | 4 | Program-counter designator |
| dp_sel_o | output | 4 | Data-pointer designator |
| instr_valid_o | output | 1 | Fetched instruction byte present on instr_o |
| instr_o | output | 8 | Fetched instruction byte |

## Verification
The hardest cases to reach from the ports are those where registers share roles. One is a load whose byte is consumed by the very next store or put. Another is a pointer stepping across the 0x0000/0xFFFF boundary. A third is both designators naming the same register while fetches and loads alternate on it. The only way to give a register a chosen value is through the accumulator, and the accumulator fills only from memory. The stimulus therefore seeds a byte stream in memory and pulls it in through register 0 with the select-register load. It then writes each byte into the target register. Directed sequences build the boundary and aliasing cases this way. A long mixed run of random codes and register numbers follows, and a behavioural model is compared against the ports on every cycle.

// File: rtl/rfu_pkg.sv
package rfu_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_NOP    = 4'd0;
    localparam logic [OP_W-1:0] OP_PUT_LO = 4'd1;
    localparam logic [OP_W-1:0] OP_PUT_HI = 4'd2;
    localparam logic [OP_W-1:0] OP_GET_LO = 4'd3;
    localparam logic [OP_W-1:0] OP_GET_HI = 4'd4;
    localparam logic [OP_W-1:0] OP_SET_PC = 4'd5;
    localparam logic [OP_W-1:0] OP_SET_DP = 4'd6;
    localparam logic [OP_W-1:0] OP_ST_DEC = 4'd7;
    localparam logic [OP_W-1:0] OP_LD_ADV = 4'd8;
    localparam logic [OP_W-1:0] OP_LD_DP  = 4'd9;
    localparam logic [OP_W-1:0] OP_LD_SEL = 4'd10;
    localparam logic [OP_W-1:0] OP_FETCH  = 4'd11;

    // which register supplies the memory address
    typedef enum logic [1:0] {
        PTR_DP  = 2'd0,
        PTR_PC  = 2'd1,
        PTR_SEL = 2'd2
    } ptr_src_e;

    // post-access adjustment of the pointer register
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;

    typedef struct packed {
        logic     mem_rd;
        logic     mem_wr;
        logic     is_fetch;
        ptr_src_e ptr;
        step_e    step;
        logic     put_lo;
        logic     put_hi;
        logic     get_lo;
        logic     get_hi;
        logic     set_pc;
        logic     set_dp;
    } ctl_t;

endpackage

// File: rtl/rfu_decode.sv
module rfu_decode
    import rfu_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output ctl_t            ctl_o
);

    always_comb begin
        ctl_o      = '0;
        ctl_o.ptr  = PTR_DP;
        ctl_o.step = STEP_NONE;
        case (op_i)
            OP_PUT_LO: ctl_o.put_lo = 1'b1;
            OP_PUT_HI: ctl_o.put_hi = 1'b1;
            OP_GET_LO: ctl_o.get_lo = 1'b1;
            OP_GET_HI: ctl_o.get_hi = 1'b1;
            OP_SET_PC: ctl_o.set_pc = 1'b1;
            OP_SET_DP: ctl_o.set_dp = 1'b1;
            OP_ST_DEC: begin
                ctl_o.mem_wr = 1'b1;
                ctl_o.step   = STEP_DEC;
            end
            OP_LD_ADV: begin
                ctl_o.mem_rd = 1'b1;
                ctl_o.step   = STEP_INC;
            end
            OP_LD_DP: begin
                ctl_o.mem_rd = 1'b1;
            end
            OP_LD_SEL: begin
                ctl_o.mem_rd = 1'b1;
                ctl_o.ptr    = PTR_SEL;
                ctl_o.step   = STEP_INC;
            end
            OP_FETCH: begin
                ctl_o.mem_rd   = 1'b1;
                ctl_o.is_fetch = 1'b1;
                ctl_o.ptr      = PTR_PC;
                ctl_o.step     = STEP_INC;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rfu_step.sv
module rfu_step
    import rfu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] val_i,
    input  step_e        step_i,
    output logic [W-1:0] val_o
);

    // plain W-bit arithmetic: wraps modulo 2^W
    always_comb begin
        case (step_i)
            STEP_INC: val_o = val_i + W'(1);
            STEP_DEC: val_o = val_i - W'(1);
            default:  val_o = val_i;
        endcase
    end

endmodule

// File: rtl/rfu_regbank.sv
module rfu_regbank #(
    parameter int NREG  = 16,
    parameter int DW    = 16,
    parameter int BW    = 8,
    parameter int IDXW  = $clog2(NREG),
    parameter int NLANE = DW / BW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [IDXW-1:0]           wr_idx_i,
    input  logic [NLANE-1:0]          wr_lane_i,
    input  logic [DW-1:0]             wr_data_i,
    output logic [NREG-1:0][DW-1:0]   regs_o
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] r_d;
        logic [DW-1:0] r_q;

        always_comb begin
            r_d = r_q;
            for (int b = 0; b < NLANE; b++) begin
                if (wr_en_i && (wr_idx_i == IDXW'(g)) && wr_lane_i[b]) begin
                    r_d[b*BW +: BW] = wr_data_i[b*BW +: BW];
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_q <= '0;
            end else begin
                r_q <= r_d;
            end
        end

        assign regs_o[g] = r_q;
    end

endmodule

// File: rtl/rfu_core.sv
module rfu_core
    import rfu_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 16,
    parameter int BW   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [OP_W-1:0]          op_i,
    input  logic [$clog2(NREG)-1:0]  sel_i,
    output logic [DW-1:0]            mem_addr_o,
    output logic                     mem_re_o,
    output logic                     mem_we_o,
    output logic [BW-1:0]            mem_wdata_o,
    input  logic [BW-1:0]            mem_rdata_i,
    output logic [BW-1:0]            acc_o,
    output logic [$clog2(NREG)-1:0]  pc_sel_o,
    output logic [$clog2(NREG)-1:0]  dp_sel_o,
    output logic                     instr_valid_o,
    output logic [BW-1:0]            instr_o
);

    localparam int IDXW  = $clog2(NREG);
    localparam int NLANE = DW / BW;
    localparam logic [NLANE-1:0] LANE_LO  = NLANE'(1);
    localparam logic [NLANE-1:0] LANE_HI  = NLANE'(1) << (NLANE - 1);
    localparam logic [NLANE-1:0] LANE_ALL = '1;

    typedef struct packed {
        logic [IDXW-1:0] pc_sel;
        logic [IDXW-1:0] dp_sel;
        logic [BW-1:0]   acc;
        logic            ld_pend;
        logic            fetch_pend;
    } state_t;

    state_t st_d, st_q;

    ctl_t                   ctl;
    logic [NREG-1:0][DW-1:0] regs;
    logic [IDXW-1:0]        ptr_idx;
    logic [DW-1:0]          ptr_val;
    logic [DW-1:0]          ptr_next;
    logic [DW-1:0]          sel_val;
    logic [BW-1:0]          acc_eff;
    logic                   put_any;
    logic                   wr_en;
    logic [IDXW-1:0]        wr_idx;
    logic [NLANE-1:0]       wr_lane;
    logic [DW-1:0]          wr_data;

    rfu_decode u_decode (
        .op_i  (op_i),
        .ctl_o (ctl)
    );

    rfu_regbank #(
        .NREG (NREG),
        .DW   (DW),
        .BW   (BW)
    ) u_regbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_lane_i (wr_lane),
        .wr_data_i (wr_data),
        .regs_o    (regs)
    );

    rfu_step #(
        .W (DW)
    ) u_step (
        .val_i  (ptr_val),
        .step_i (ctl.step),
        .val_o  (ptr_next)
    );

    // pointer and operand selection
    always_comb begin
        case (ctl.ptr)
            PTR_PC:  ptr_idx = st_q.pc_sel;
            PTR_SEL: ptr_idx = sel_i;
            default: ptr_idx = st_q.dp_sel;
        endcase
        ptr_val = regs[ptr_idx];
        sel_val = regs[sel_i];
        // a byte requested last cycle is the accumulator from now on
        acc_eff = st_q.ld_pend ? mem_rdata_i : st_q.acc;
    end

    // register write port: byte puts or pointer step-back
    always_comb begin
        put_any = ctl.put_lo | ctl.put_hi;
        wr_en   = put_any | ((ctl.mem_rd | ctl.mem_wr) & (ctl.step != STEP_NONE));
        wr_idx  = put_any ? sel_i : ptr_idx;
        wr_data = put_any ? {NLANE{acc_eff}} : ptr_next;
        if (ctl.put_lo) begin
            wr_lane = LANE_LO;
        end else if (ctl.put_hi) begin
            wr_lane = LANE_HI;
        end else begin
            wr_lane = LANE_ALL;
        end
    end

    // next state
    always_comb begin
        st_d     = st_q;
        st_d.acc = acc_eff;
        if (ctl.get_lo) begin
            st_d.acc = sel_val[BW-1:0];
        end
        if (ctl.get_hi) begin
            st_d.acc = sel_val[DW-1 -: BW];
        end
        if (ctl.set_pc) begin
            st_d.pc_sel = sel_i;
        end
        if (ctl.set_dp) begin
            st_d.dp_sel = sel_i;
        end
        st_d.ld_pend    = ctl.mem_rd & ~ctl.is_fetch;
        st_d.fetch_pend = ctl.is_fetch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr_o    = ptr_val;
    assign mem_re_o      = ctl.mem_rd;
    assign mem_we_o      = ctl.mem_wr;
    assign mem_wdata_o   = acc_eff;
    assign acc_o         = acc_eff;
    assign pc_sel_o      = st_q.pc_sel;
    assign dp_sel_o      = st_q.dp_sel;
    assign instr_valid_o = st_q.fetch_pend;
    assign instr_o       = mem_rdata_i;

endmodule

// File: rtl/rfu_core_chk.sv
module rfu_core_chk #(
    parameter int IDXW = 4,
    parameter int DW   = 16,
    parameter int BW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      op_i,
    input logic [IDXW-1:0] sel_i,
    input logic [DW-1:0]   mem_addr_o,
    input logic            mem_re_o,
    input logic            mem_we_o,
    input logic [BW-1:0]   mem_rdata_i,
    input logic [BW-1:0]   acc_o,
    input logic [IDXW-1:0] pc_sel_o,
    input logic [IDXW-1:0] dp_sel_o,
    input logic            instr_valid_o
);

    logic past_ok;
    logic is_nop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    assign is_nop = (op_i == 4'd0) || (op_i >= 4'd12);

    a_r12_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re_o && mem_we_o));

    a_r11_nop_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        is_nop |-> (!mem_re_o && !mem_we_o));

    a_r11_nop_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && is_nop) |=>
            (pc_sel_o == $past(pc_sel_o)) && (dp_sel_o == $past(dp_sel_o)) && (acc_o == $past(acc_o)));

    a_r4_set_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd5) |=> (pc_sel_o == $past(sel_i)));

    a_r4_set_dp: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd6) |=> (dp_sel_o == $past(sel_i)));

    a_r8_fetch_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd11) |=> instr_valid_o);

    a_r8_no_stray_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && op_i != 4'd11) |=> !instr_valid_o);

    a_r9_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd8 || op_i == 4'd9 || op_i == 4'd10) |=> (acc_o == mem_rdata_i));

    a_r5_down_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && op_i == 4'd7 && $past(op_i) == 4'd7) |->
            (mem_addr_o == DW'($past(mem_addr_o) - 1'b1)));

    a_r6_up_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && op_i == 4'd8 && $past(op_i) == 4'd8) |->
            (mem_addr_o == DW'($past(mem_addr_o) + 1'b1)));

endmodule

bind rfu_core rfu_core_chk #(
    .IDXW ($clog2(NREG)),
    .DW   (DW),
    .BW   (BW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_i          (op_i),
    .sel_i         (sel_i),
    .mem_addr_o    (mem_addr_o),
    .mem_re_o      (mem_re_o),
    .mem_we_o      (mem_we_o),
    .mem_rdata_i   (mem_rdata_i),
    .acc_o         (acc_o),
    .pc_sel_o      (pc_sel_o),
    .dp_sel_o      (dp_sel_o),
    .instr_valid_o (instr_valid_o)
);

// File: tb/rfu_core_tb.sv
module rfu_core_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic [3:0]  sel_i = '0;
    logic [15:0] mem_addr_o;
    logic        mem_re_o;
    logic        mem_we_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i = '0;
    logic [7:0]  acc_o;
    logic [3:0]  pc_sel_o;
    logic [3:0]  dp_sel_o;
    logic        instr_valid_o;
    logic [7:0]  instr_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rfu_core u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_i          (op_i),
        .sel_i         (sel_i),
        .mem_addr_o    (mem_addr_o),
        .mem_re_o      (mem_re_o),
        .mem_we_o      (mem_we_o),
        .mem_wdata_o   (mem_wdata_o),
        .mem_rdata_i   (mem_rdata_i),
        .acc_o         (acc_o),
        .pc_sel_o      (pc_sel_o),
        .dp_sel_o      (dp_sel_o),
        .instr_valid_o (instr_valid_o),
        .instr_o       (instr_o)
    );

    // background content of never-written bytes
    function automatic int bg(int a);
        return (a ^ (a >> 8) ^ 'h5A) & 'hFF;
    endfunction

    // environment memory, driven only by the design's strobes
    logic [7:0] env_mem [int];
    always @(posedge clk) begin
        if (mem_we_o) env_mem[int'(mem_addr_o)] = mem_wdata_o;
        if (mem_re_o) mem_rdata_i <= env_mem.exists(int'(mem_addr_o)) ?
                                     env_mem[int'(mem_addr_o)] : 8'(bg(int'(mem_addr_o)));
    end

    // behavioural model
    int mr [16];
    int mp, mx, macc, maddr;
    bit mld, mfp;
    int mm [int];
    int stream;

    function automatic int mread(int a);
        return mm.exists(a) ? mm[a] : bg(a);
    endfunction

    task automatic poke(int a, int v);
        env_mem[a] = 8'(v);
        mm[a] = v & 'hFF;
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(int o, int s, string tag);
        int acc_eff, ptr, addr, nacc;
        bit rd, wr;
        @(negedge clk);
        op_i  = 4'(o);
        sel_i = 4'(s);
        #1;
        acc_eff = mld ? mread(maddr) : macc;
        rd = (o == 8) || (o == 9) || (o == 10) || (o == 11);
        wr = (o == 7);
        ptr = (o == 10) ? s : (o == 11) ? mp : mx;
        addr = mr[ptr];
        chk(tag, "acc", int'(acc_o), acc_eff);
        chk(tag, "pc_sel", int'(pc_sel_o), mp);
        chk(tag, "dp_sel", int'(dp_sel_o), mx);
        chk(tag, "re", int'(mem_re_o), int'(rd));
        chk(tag, "we", int'(mem_we_o), int'(wr));
        chk(tag, "instr_valid", int'(instr_valid_o), int'(mfp));
        if (mfp) chk(tag, "instr", int'(instr_o), mread(maddr));
        if (rd || wr) chk(tag, "addr", int'(mem_addr_o), addr);
        if (wr) chk(tag, "wdata", int'(mem_wdata_o), acc_eff);
        nacc = acc_eff;
        case (o)
            1: mr[s] = (mr[s] & 'hFF00) | acc_eff;
            2: mr[s] = (mr[s] & 'h00FF) | (acc_eff << 8);
            3: nacc = mr[s] & 'hFF;
            4: nacc = (mr[s] >> 8) & 'hFF;
            5: mp = s;
            6: mx = s;
            7: begin mm[addr] = acc_eff; mr[ptr] = (addr - 1) & 'hFFFF; end
            8, 10, 11: mr[ptr] = (addr + 1) & 'hFFFF;
            default: ;
        endcase
        mld = (o == 8) || (o == 9) || (o == 10);
        mfp = (o == 11);
        maddr = addr;
        macc = nacc;
    endtask

    // put a chosen 16-bit value into register n (n != 0) through the stream at R0
    task automatic set_reg(int n, int v);
        poke(stream, v & 'hFF);
        step(10, 0, "R7");
        step(1, n, "R2");
        poke(stream + 1, (v >> 8) & 'hFF);
        step(10, 0, "R7");
        step(2, n, "R2");
        stream += 2;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        foreach (mr[i]) mr[i] = 0;
        mp = 0; mx = 0; macc = 0; maddr = 0; mld = 0; mfp = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and first fetch from address 0 via R0
        step(0, 0, "R1");
        step(11, 0, "R1");
        step(11, 0, "R8");
        step(11, 0, "R8");
        step(0, 0, "R8");
        stream = 3;

        // R2 / R3: byte puts and gets
        set_reg(3, 'h1234);
        step(3, 3, "R3");
        step(4, 3, "R3");
        step(0, 0, "R3");
        poke(stream, 'hA5); step(10, 0, "R7"); stream++;
        step(1, 3, "R2");
        step(4, 3, "R2");
        step(3, 3, "R2");
        step(0, 0, "R2");

        // R4 / R10 / R6: pointer wraps upward
        set_reg(5, 'hFFFF);
        step(6, 5, "R4");
        poke('hFFFF, 'h3C);
        step(8, 0, "R10");
        step(3, 5, "R10");
        step(4, 5, "R10");
        step(0, 0, "R6");

        // R5 / R10: store and step down across zero, consecutive stores
        poke(stream, 'h77); step(10, 0, "R7"); stream++;
        step(7, 0, "R10");
        step(7, 0, "R5");
        step(4, 5, "R5");
        step(3, 5, "R5");
        step(9, 0, "R6");
        step(9, 0, "R6");
        step(0, 0, "R6");

        // R9: load forwarded into store and into put
        set_reg(6, 'h0040);
        step(6, 6, "R4");
        step(8, 0, "R9");
        step(7, 0, "R9");
        step(8, 0, "R9");
        step(2, 7, "R9");
        step(4, 7, "R9");
        step(0, 0, "R9");

        // R8: program counter moved to another register, aliased with data pointer
        step(5, 3, "R4");
        step(11, 0, "R8");
        step(6, 3, "R8");
        step(11, 0, "R8");
        step(8, 0, "R8");
        step(11, 0, "R8");
        step(0, 0, "R8");

        // R11: every no-operation code
        for (int c = 12; c < 16; c++) step(c, c - 8, "R11");
        step(0, 9, "R11");
        step(3, 3, "R11");
        step(0, 0, "R11");

        // R12: long mixed run
        for (int k = 0; k < 2000; k++) begin
            int o;
            int s;
            o = int'($urandom_range(0, 15));
            s = int'($urandom_range(0, 15));
            step(o, s, "R12");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule